// File: doc/BRIEF.md
# Synchronous Send Strobe Timing Generator

This block produces the send-side timing of a parallel synchronous bus. It drives the data bus, the bus output-enable and one strobe line. In single-transition (ST) mode it sends one word per strobe pulse. In double-transition (DT) mode it sends one word on every strobe toggle. The rising strobe edge is the ST edge. In DT mode the falling edge is the DT edge. The spacing of the edges comes from a divisor code. Four configuration bits can each add one clock of data setup before, or one clock of data hold after, either the ST edge or the DT edge. This lowers only the send rate; a receiver is still paced by the divisor alone.

Words arrive through a valid/ready handshake. Ready is raised only in a launch slot, which is the last clock of the previous word's hold phase or the wait state. The sequencer has six states:
- `ST_IDLE`: disabled.
- `ST_WAIT`: enabled, no word pending.
- `ST_SETUP`: base setup count before the edge.
- `ST_XSETUP`: the optional extra setup clock.
- `ST_HOLD`: base hold count after the edge.
- `ST_XHOLD`: the optional extra hold clock.

Its transitions are:
- enable (IDLE to WAIT)
- launch (WAIT, or the end of hold, to SETUP)
- setup stretch (SETUP to XSETUP)
- strobe edge (SETUP or XSETUP to HOLD)
- hold stretch (HOLD to XHOLD)
- starve (end of hold to WAIT)
- disable (any state to IDLE)

Top module: `sts_strobe_gen`

## Requirements
- R1: After reset, and while `en` is low, `strobe` is 0, `bus_oe` is 0 and `tx_ready` is 0.
- R2: One clock after `en` rises, `tx_ready` is 1. A word accepted on a clock edge with `tx_valid` and `tx_ready` both high appears on `bus_data` after that edge, with `bus_oe` high.
- R3: ST mode, with divisor D (D = code, or 1 when the code is 0) and no extra bits. The strobe rises 2D clocks after the data change and falls 2D clocks after rising. The next word appears on the same edge as the fall, giving a period of 4D clocks.
- R4: DT mode with no extra bits. The strobe toggles once per word. Each word is on the bus D clocks before its edge and D clocks after it. Rising edges are ST edges and falling edges are DT edges, starting from a low strobe.
- R5: `xs_st` adds one clock between the data change and the rising edge, in both modes.
- R6: `xh_st` adds one clock between the rising edge and the next data change, in both modes.
- R7: `xs_dt` adds one clock between the data change and a falling edge in DT mode, and has no effect in ST mode.
- R8: `xh_dt` adds one clock between a falling edge and the next data change in DT mode, and has no effect in ST mode.
- R9: A divisor code of 0 gives the same timing as a code of 1.
- R10: One clock after `en` falls, `strobe` and `bus_oe` are 0. `tx_ready` is 0 as soon as `en` is low.
- R11: Outside a launch slot `tx_ready` is 0. `bus_data` changes only on an accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Send enable |
| dt_mode | input | 1 | 1 = double-transition, 0 = single-transition |
| div_code | input | DIV_W | Edge spacing divisor (0 acts as 1) |
| xs_st | input | 1 | Extra setup clock before the ST (rising) edge |
| xh_st | input | 1 | Extra hold clock after the ST edge |
| xs_dt | input | 1 | Extra setup clock before the DT (falling) edge |
| xh_dt | input | 1 | Extra hold clock after the DT edge |
| tx_data | input | DATA_W | Word to send |
| tx_valid | input | 1 | Word is offered |
| tx_ready | output | 1 | Launch slot: the word is taken on this edge |
| bus_data | output | DATA_W | Bus data |
| bus_oe | output | 1 | Bus output-enable |
| strobe | output | 1 | Transfer strobe |

## Verification
Every timing result is an interval counted in clocks between a data change and a strobe edge. It is due exactly setup (P plus the setup bit) or hold (P plus the hold bit) clocks after the previous event, where P is 2D in ST mode and D in DT mode. A monitor stamps each strobe and data change with a cycle count sampled on the falling clock edge. The checks compare the differences of those stamps against values computed from D and the four bits. Handshake and enable results are due one clock after the stimulus, and are sampled on the next falling edge. The exception is `tx_ready` after `en` falls, which is combinational and checked on the same half cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_XSETUP,
        ST_HOLD,
        ST_XHOLD
    } sts_state_e;

endpackage

// File: rtl/sts_edge_cfg.sv
// Picks the phase length and the setup/hold extensions for the next edge.
module sts_edge_cfg #(
    parameter int DIV_W = 4,
    parameter int CNT_W = DIV_W + 1
) (
    input  logic             dt_mode,
    input  logic             strobe_lvl,
    input  logic [DIV_W-1:0] div_code,
    input  logic             xs_st,
    input  logic             xh_st,
    input  logic             xs_dt,
    input  logic             xh_dt,
    output logic [CNT_W-1:0] phase_len,
    output logic             add_setup,
    add_hold
);
    logic [CNT_W-1:0] d_eff;
    logic             st_edge;

    always_comb begin
        d_eff = (div_code == '0) ? CNT_W'(1) : CNT_W'(div_code);
        // ST mode: every edge is the rising one; DT: rising when strobe is low
        st_edge   = !dt_mode || !strobe_lvl;
        phase_len = dt_mode ? d_eff : (d_eff << 1);
        add_setup = st_edge ? xs_st : xs_dt;
        add_hold  = st_edge ? xh_st : xh_dt;
    end

endmodule

// File: rtl/sts_phase_cnt.sv
// Loadable down counter; a load of L gives L cycles until cnt_zero.
module sts_phase_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/sts_seq_fsm.sv
// Sequencer: launch, setup, strobe edge, hold, with optional stretch clocks.
module sts_seq_fsm
    import sts_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             dt_mode,
    input  logic             tx_valid,
    input  logic             cnt_zero,
    input  logic [CNT_W-1:0] phase_len,
    input  logic             add_setup,
    input  logic             add_hold,
    output logic             tx_ready,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             dec,
    output logic             strobe,
    output logic             oe
);
    sts_state_e       state_q, state_d;
    logic             strobe_q, strobe_d;
    logic             oe_q, oe_d;
    logic             dt_q, dt_d;
    logic             xs_q, xs_d;
    logic             xh_q, xh_d;
    logic [CNT_W-1:0] plen_q, plen_d;
    logic             launch_slot;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            strobe_q <= 1'b0;
            oe_q     <= 1'b0;
            dt_q     <= 1'b0;
            xs_q     <= 1'b0;
            xh_q     <= 1'b0;
            plen_q   <= CNT_W'(1);
        end else begin
            state_q  <= state_d;
            strobe_q <= strobe_d;
            oe_q     <= oe_d;
            dt_q     <= dt_d;
            xs_q     <= xs_d;
            xh_q     <= xh_d;
            plen_q   <= plen_d;
        end
    end

    // Next state and output process
    always_comb begin
        state_d  = state_q;
        strobe_d = strobe_q;
        oe_d     = oe_q;
        dt_d     = dt_q;
        xs_d     = xs_q;
        xh_d     = xh_q;
        plen_d   = plen_q;
        load     = 1'b0;
        load_val = plen_q;
        dec      = 1'b0;

        launch_slot = (state_q == ST_WAIT) || (state_q == ST_XHOLD)
                   || (state_q == ST_HOLD && cnt_zero && !xh_q);
        tx_ready = en && launch_slot;
        accept   = tx_ready && tx_valid;

        if (!en) begin
            state_d  = ST_IDLE;
            strobe_d = 1'b0;
            oe_d     = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_WAIT;
                ST_WAIT, ST_XHOLD: ;
                ST_SETUP: begin
                    if (!cnt_zero) begin
                        dec = 1'b1;
                    end else if (xs_q) begin
                        state_d = ST_XSETUP;
                    end else begin
                        strobe_d = !strobe_q;
                        state_d  = ST_HOLD;
                        load     = 1'b1;
                    end
                end
                ST_XSETUP: begin
                    strobe_d = !strobe_q;
                    state_d  = ST_HOLD;
                    load     = 1'b1;
                end
                ST_HOLD: begin
                    if (!cnt_zero) begin
                        dec = 1'b1;
                    end else if (xh_q) begin
                        state_d = ST_XHOLD;
                    end
                end
                default: state_d = ST_IDLE;
            endcase

            if (launch_slot) begin
                if (tx_valid) begin
                    state_d  = ST_SETUP;
                    load     = 1'b1;
                    load_val = phase_len;
                    plen_d   = phase_len;
                    oe_d     = 1'b1;
                    dt_d     = dt_mode;
                    xs_d     = add_setup;
                    xh_d     = add_hold;
                    if (!dt_mode) strobe_d = 1'b0;
                end else if (state_q != ST_WAIT) begin
                    state_d = ST_WAIT;
                    if (!dt_q) strobe_d = 1'b0;
                end
            end
        end
    end

    assign strobe = strobe_q;
    assign oe     = oe_q;

endmodule

// File: rtl/sts_strobe_gen.sv
module sts_strobe_gen #(
    parameter int DIV_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dt_mode,
    input  logic [DIV_W-1:0]  div_code,
    input  logic              xs_st,
    input  logic              xh_st,
    input  logic              xs_dt,
    input  logic              xh_dt,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              strobe
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]  phase_len, load_val;
    logic              add_setup, add_hold;
    logic              cnt_zero, load, dec, accept;
    logic [DATA_W-1:0] data_q;

    sts_edge_cfg #(.DIV_W(DIV_W), .CNT_W(CNT_W)) cfg_i (
        .dt_mode   (dt_mode),
        .strobe_lvl(strobe),
        .div_code  (div_code),
        .xs_st     (xs_st),
        .xh_st     (xh_st),
        .xs_dt     (xs_dt),
        .xh_dt     (xh_dt),
        .phase_len (phase_len),
        .add_setup (add_setup),
        .add_hold  (add_hold)
    );

    sts_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .dec     (dec),
        .cnt_zero(cnt_zero)
    );

    sts_seq_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .dt_mode  (dt_mode),
        .tx_valid (tx_valid),
        .cnt_zero (cnt_zero),
        .phase_len(phase_len),
        .add_setup(add_setup),
        .add_hold (add_hold),
        .tx_ready (tx_ready),
        .accept   (accept),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .strobe   (strobe),
        .oe       (bus_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= tx_data;
        end
    end

    assign bus_data = data_q;

endmodule

// File: rtl/sts_strobe_gen_chk.sv
module sts_strobe_gen_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_oe,
    input logic              strobe
);
    // R1 / R10: disabled sequencer parks the strobe and releases the bus
    a_r1_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!strobe && !bus_oe));

    // R2: accepted word is driven next cycle with output-enable
    a_r2_launch_word: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (bus_oe && bus_data == $past(tx_data)));

    // R11: bus data holds between accepting edges
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_ready) |=> $stable(bus_data));

    // R4: a strobe edge is only produced while the bus is driven
    a_r4_edge_driven: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> bus_oe);

    // R10: no handshake while disabled
    a_r10_ready_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> !tx_ready);

endmodule

bind sts_strobe_gen sts_strobe_gen_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tx_data (tx_data),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .bus_data(bus_data),
    .bus_oe  (bus_oe),
    .strobe  (strobe)
);

// File: tb/sts_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module sts_strobe_gen_tb_top;
    localparam int DIV_W  = 4;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0, dt_mode = 1'b0;
    logic [DIV_W-1:0]  div_code = '0;
    logic              xs_st = 0, xh_st = 0, xs_dt = 0, xh_dt = 0;
    logic [DATA_W-1:0] tx_data = '0;
    logic              tx_valid = 1'b0;
    logic              tx_ready, bus_oe, strobe;
    logic [DATA_W-1:0] bus_data;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sts_strobe_gen #(.DIV_W(DIV_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .dt_mode(dt_mode), .div_code(div_code),
        .xs_st(xs_st), .xh_st(xh_st), .xs_dt(xs_dt), .xh_dt(xh_dt),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .bus_data(bus_data), .bus_oe(bus_oe), .strobe(strobe)
    );

    // Event monitor: stamps strobe and data changes at falling edges
    int cyc = 0, ns = 0, nd = 0;
    int st_t[16];
    int dt_t[16];
    logic prev_s = 0;
    logic [DATA_W-1:0] prev_d = '0;
    bit mon_clr = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            ns = 0; nd = 0; prev_s = strobe; prev_d = bus_data;
        end else begin
            if (strobe !== prev_s) begin
                if (ns < 16) st_t[ns] = cyc;
                ns++;
                prev_s = strobe;
            end
            if (bus_data !== prev_d) begin
                if (nd < 16) dt_t[nd] = cyc;
                nd++;
                prev_d = bus_data;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic quiesce();
        @(negedge clk);
        en = 0; tx_valid = 0;
        repeat (3) @(negedge clk);
        mon_clr = 1;
        @(negedge clk);
        mon_clr = 0;
    endtask

    task automatic send_words(int n, logic [DATA_W-1:0] base);
        int k = 0;
        tx_data = base; tx_valid = 1; en = 1;
        while (k < n) begin
            @(negedge clk);
            if (tx_ready) begin
                @(posedge clk); #1;
                k++;
                tx_data = base + DATA_W'(k);
                if (k == n) tx_valid = 0;
            end
        end
        repeat (40) @(negedge clk);
    endtask

    // ST mode: word 1 setup and hold around its rising edge
    task automatic run_st(string req, int code, bit a, bit b, bit c, bit d,
                          int exp_su, int exp_ho, logic [DATA_W-1:0] base);
        quiesce();
        dt_mode = 0; div_code = DIV_W'(code);
        xs_st = a; xh_st = b; xs_dt = c; xh_dt = d;
        send_words(4, base);
        chk({req, " st setup"}, st_t[2] - dt_t[1], exp_su);
        chk({req, " st hold"},  dt_t[2] - st_t[2], exp_ho);
        chk({req, " st fall at launch"}, st_t[1], dt_t[1]);
    endtask

    // DT mode: word 1 uses the falling edge, word 2 the rising edge
    task automatic run_dt(string req, int code, bit a, bit b, bit c, bit d,
                          int d_eff, logic [DATA_W-1:0] base);
        quiesce();
        dt_mode = 1; div_code = DIV_W'(code);
        xs_st = a; xh_st = b; xs_dt = c; xh_dt = d;
        send_words(5, base);
        chk({req, " dt fall setup"}, st_t[1] - dt_t[1], d_eff + int'(c));
        chk({req, " dt fall hold"},  dt_t[2] - st_t[1], d_eff + int'(d));
        chk({req, " dt rise setup"}, st_t[2] - dt_t[2], d_eff + int'(a));
        chk({req, " dt rise hold"},  dt_t[3] - st_t[2], d_eff + int'(b));
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1 strobe", int'(strobe), 0);
        chk("R1 oe", int'(bus_oe), 0);
        chk("R1 ready", int'(tx_ready), 0);
    endtask

    task automatic test_handshake();
        quiesce();
        dt_mode = 0; div_code = 4'd1; xs_st = 0; xh_st = 0; xs_dt = 0; xh_dt = 0;
        en = 1;
        @(negedge clk);
        chk("R2 ready after enable", int'(tx_ready), 1);
        tx_data = 16'h5A5A; tx_valid = 1;
        @(negedge clk);
        chk("R2 data on bus", int'(bus_data), 16'h5A5A);
        chk("R2 oe high", int'(bus_oe), 1);
        chk("R11 ready off in setup", int'(tx_ready), 0);
        tx_data = 16'h1234;
        @(negedge clk);
        chk("R11 data held", int'(bus_data), 16'h5A5A);
        tx_valid = 0;
    endtask

    task automatic test_disable();
        int guard = 0;
        quiesce();
        dt_mode = 1; div_code = 4'd2; xs_st = 0; xh_st = 0; xs_dt = 0; xh_dt = 0;
        tx_data = 16'h7000; tx_valid = 1; en = 1;
        while (strobe !== 1'b1 && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk("R10 strobe reached high", int'(strobe), 1);
        en = 0;
        #1;
        chk("R10 ready drops with en", int'(tx_ready), 0);
        @(negedge clk);
        chk("R10 strobe idle", int'(strobe), 0);
        chk("R10 oe off", int'(bus_oe), 0);
        tx_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        test_reset();
        test_handshake();
        run_st("R3", 2, 0, 0, 0, 0, 4, 4, 16'hA000);
        run_st("R5", 3, 1, 0, 0, 0, 7, 6, 16'hA100);
        run_st("R6 R7 R8", 2, 0, 1, 1, 1, 4, 5, 16'hA200);
        run_st("R9", 0, 0, 0, 0, 0, 2, 2, 16'hA300);
        run_dt("R4", 2, 0, 0, 0, 0, 2, 16'hB000);
        run_dt("R7 R6", 1, 0, 1, 1, 0, 1, 16'hB100);
        run_dt("R8 R5", 2, 1, 0, 0, 1, 2, 16'hB200);
        test_disable();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule